// File: doc/BRIEF.md
# Backplane Ethernet Link Bring-Up Sequencer

This block is the control state machine that brings up a multi-rate backplane Ethernet PHY. After a reset, or after software restarts it, the sequencer picks a start point from its configuration. It then moves through auto-negotiation (AN), link training (LT) and a data mode. On entry to each phase it presents a one-hot reconfiguration request to the PCS. It holds that request until the PCS answers with a reconfiguration-done pulse, and only then waits for the phase's own outcome.

A forced-protocol setting can skip negotiation, jump straight to a data mode, or park the sequencer. A failure-response setting decides what happens when training fails or times out: go straight to data, restart negotiation, or retrain. Forced protocol, AN enable and FEC request are sampled only when the sequencer restarts. Changing them during a running link has no effect until the next restart. Sticky timeout flags report negotiation and training timeouts. A separate write strobe produces a one-cycle FEC transmit error-insert pulse.

Top module: `bp_link_seq`

## Requirements
- R1: Under reset and for the cycle after a restart strobe, `rcfg_mode` is 0 and `link_ready` is 0. With `cfg_force`=0000 and `cfg_an_en`=1, the first request after reset is AN (`rcfg_mode`=000001). `lt_timeout` is cleared one cycle after the sequencer passes through its start state.
- R2: `cfg_force` codes are handled as follows. 0000 runs the negotiated flow. 0101 runs the same flow with FEC never chosen and the AN speed result ignored. 1100 runs the same flow with FEC data always chosen. 0001 goes straight to a GigE data request (001000). 0100 goes straight to a 10G data request (000100). 0010 and every other code park the sequencer with `rcfg_mode`=0.
- R3: `rcfg_mode` is one-hot or zero. The bits mean: bit0 AN, bit1 LT, bit2 10G data, bit3 GigE data, bit5 10G FEC data. Bit4 is never driven.
- R4: A request stays stable on `rcfg_mode` until `rcfg_done` is seen. Outcome pulses (`an_done`, `lt_done`, `lt_fail`) that arrive before that are ignored.
- R5: When AN completes in the unforced flow, `an_res_10g`=1 leads to an LT request and `an_res_10g`=0 leads to a GigE data request.
- R6: After training, FEC data (100000) is requested only when the FEC request sampled at restart was 1 and the partner reported FEC ability at AN completion. Otherwise 10G data (000100) is requested. Without AN the partner ability counts as 0.
- R7: On `lt_fail`, `cfg_lt_fail_data`=1 requests the 10G data mode. Otherwise the sequencer re-requests AN when AN is enabled, and re-requests LT when it is not.
- R8: An AN wait longer than `AN_TMO` cycles sets `an_timeout` and re-requests AN. The flag stays set until a fresh AN attempt starts, either from the start state or after a training failure.
- R9: An LT wait longer than `LT_TMO` cycles sets `lt_timeout` and applies the same response as `lt_fail`.
- R10: Changes to `cfg_force`, `cfg_an_en` and `cfg_fec_req` made after the sequencer has left its start state do not change the running flow.
- R11: `link_ready` is 1 only after the data request has been acknowledged by `rcfg_done`, and it stays 1 until a restart.
- R12: Each cycle with `cfg_err_ins`=1 produces exactly one `fec_err_pulse` cycle, on the following cycle.
- R13: A restart strobe takes priority over any outcome or `rcfg_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_restart | input | 1 | Sequencer restart strobe; samples configuration |
| cfg_force | input | 4 | Forced protocol code |
| cfg_an_en | input | 1 | Auto-negotiation enable |
| cfg_fec_req | input | 1 | Local FEC request |
| cfg_lt_fail_data | input | 1 | Training failure goes straight to data mode |
| cfg_err_ins | input | 1 | FEC transmit error-insert write strobe |
| an_done | input | 1 | Negotiation complete pulse |
| an_res_10g | input | 1 | Negotiated rate is 10G (else GigE) |
| an_partner_fec | input | 1 | Partner reported FEC ability |
| lt_done | input | 1 | Training success pulse |
| lt_fail | input | 1 | Training failure pulse |
| rcfg_done | input | 1 | PCS reconfiguration complete pulse |
| rcfg_mode | output | 6 | One-hot reconfiguration mode request |
| link_ready | output | 1 | Link up in a data mode |
| an_timeout | output | 1 | Sticky AN timeout flag |
| lt_timeout | output | 1 | LT timeout flag |
| fec_err_pulse | output | 1 | Single-cycle FEC error-insert pulse |

## Verification
The restart strobe can fall in the same cycle as a PCS acknowledge. It can also fall in the same cycle as an error-insert write. The bench raises `cfg_restart`, `rcfg_done` and `cfg_err_ins` together while a 10G data request is outstanding. It expects `rcfg_mode` to drop to zero and `link_ready` to stay low, which means the acknowledge was discarded. It also expects the error pulse to appear on the next cycle anyway, and the new AN request to follow one cycle later. A second coincidence is `lt_done` against the training timeout. The design lets the done pulse win, so a training pass that arrives in the expiring cycle still counts as a pass.

// File: rtl/bls_pkg.sv
package bls_pkg;

  localparam int MODE_W = 6;

  typedef enum logic [2:0] {
    ST_START, ST_PARK, ST_AN_REQ, ST_AN_WAIT,
    ST_LT_REQ, ST_LT_WAIT, ST_DAT_REQ, ST_DATA
  } seq_st_t;

  localparam logic [MODE_W-1:0] M_NONE  = 6'b000000;
  localparam logic [MODE_W-1:0] M_AN    = 6'b000001;
  localparam logic [MODE_W-1:0] M_LT    = 6'b000010;
  localparam logic [MODE_W-1:0] M_10G   = 6'b000100;
  localparam logic [MODE_W-1:0] M_GIGE  = 6'b001000;
  localparam logic [MODE_W-1:0] M_FEC   = 6'b100000;

  localparam logic [3:0] FRC_NONE  = 4'b0000;
  localparam logic [3:0] FRC_GIGE  = 4'b0001;
  localparam logic [3:0] FRC_XAUI  = 4'b0010;
  localparam logic [3:0] FRC_10GR  = 4'b0100;
  localparam logic [3:0] FRC_KR    = 4'b0101;
  localparam logic [3:0] FRC_KRFEC = 4'b1100;

  // First phase after the start state.
  function automatic seq_st_t start_target(logic [3:0] frc, logic an_en);
    case (frc)
      FRC_NONE, FRC_KR, FRC_KRFEC: start_target = an_en ? ST_AN_REQ : ST_LT_REQ;
      FRC_GIGE, FRC_10GR:          start_target = ST_DAT_REQ;
      default:                     start_target = ST_PARK;
    endcase
  endfunction

  // Data mode fixed at start for directly forced protocols.
  function automatic logic [MODE_W-1:0] start_data(logic [3:0] frc);
    case (frc)
      FRC_GIGE: start_data = M_GIGE;
      FRC_10GR: start_data = M_10G;
      default:  start_data = M_NONE;
    endcase
  endfunction

  // 10G data flavour after training.
  function automatic logic [MODE_W-1:0] tengig_data(logic [3:0] frc, logic fec_req,
                                                    logic partner_fec);
    if (frc == FRC_KRFEC)
      tengig_data = M_FEC;
    else if (frc == FRC_NONE && fec_req && partner_fec)
      tengig_data = M_FEC;
    else
      tengig_data = M_10G;
  endfunction

  // Where a failed or timed-out training goes.
  function automatic seq_st_t lt_fail_target(logic to_data, logic an_en);
    if (to_data)   lt_fail_target = ST_DAT_REQ;
    else if (an_en) lt_fail_target = ST_AN_REQ;
    else           lt_fail_target = ST_LT_REQ;
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(seq_st_t st, logic [MODE_W-1:0] dm);
    case (st)
      ST_AN_REQ, ST_AN_WAIT: mode_of = M_AN;
      ST_LT_REQ, ST_LT_WAIT: mode_of = M_LT;
      ST_DAT_REQ, ST_DATA:   mode_of = dm;
      default:               mode_of = M_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bls_timer.sv
module bls_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/bls_err_pulse.sv
module bls_err_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  output logic pulse
);
  // The written bit lives for one cycle only, so it clears itself.
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= wr;
  end
endmodule

// File: rtl/bls_fsm.sv
module bls_fsm
  import bls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [3:0]        force_code,
  input  logic              an_en,
  input  logic              fec_req,
  input  logic              lt_fail_data,
  input  logic              an_done,
  input  logic              an_res_10g,
  input  logic              an_partner_fec,
  input  logic              lt_done,
  input  logic              lt_fail,
  input  logic              rcfg_done,
  input  logic              an_expired,
  input  logic              lt_expired,
  output seq_st_t           st,
  output logic [MODE_W-1:0] data_mode,
  output logic              an_to,
  output logic              lt_to,
  output logic              an_tmo_evt,
  output logic              lt_tmo_evt,
  output logic              an_start_evt
);
  seq_st_t           nxt;
  logic [MODE_W-1:0] nxt_dm;
  logic [3:0]        sh_force;
  logic              sh_an_en;
  logic              sh_fec_req;
  logic              partner_fec;
  logic              lt_bad;

  // Done wins over an expiring training window.
  assign lt_bad = lt_fail || (lt_expired && !lt_done);

  always_comb begin
    nxt        = st;
    nxt_dm     = data_mode;
    an_tmo_evt = 1'b0;
    lt_tmo_evt = 1'b0;
    if (restart) begin
      nxt = ST_START;
    end else begin
      case (st)
        ST_START: begin
          nxt    = start_target(force_code, an_en);
          nxt_dm = start_data(force_code);
        end
        ST_PARK: nxt = ST_PARK;
        ST_AN_REQ: if (rcfg_done) nxt = ST_AN_WAIT;
        ST_AN_WAIT: begin
          if (an_done) begin
            if (sh_force == FRC_NONE && !an_res_10g) begin
              nxt    = ST_DAT_REQ;
              nxt_dm = M_GIGE;
            end else begin
              nxt = ST_LT_REQ;
            end
          end else if (an_expired) begin
            nxt        = ST_AN_REQ;
            an_tmo_evt = 1'b1;
          end
        end
        ST_LT_REQ: if (rcfg_done) nxt = ST_LT_WAIT;
        ST_LT_WAIT: begin
          if (lt_bad) begin
            nxt        = lt_fail_target(lt_fail_data, sh_an_en);
            nxt_dm     = tengig_data(sh_force, sh_fec_req, partner_fec);
            lt_tmo_evt = !lt_fail;
          end else if (lt_done) begin
            nxt    = ST_DAT_REQ;
            nxt_dm = tengig_data(sh_force, sh_fec_req, partner_fec);
          end
        end
        ST_DAT_REQ: if (rcfg_done) nxt = ST_DATA;
        default: nxt = st;
      endcase
    end
  end

  assign an_start_evt = (nxt == ST_AN_REQ) && ((st == ST_START) || (st == ST_LT_WAIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_START;
      data_mode   <= M_NONE;
      sh_force    <= FRC_NONE;
      sh_an_en    <= 1'b0;
      sh_fec_req  <= 1'b0;
      partner_fec <= 1'b0;
      an_to       <= 1'b0;
      lt_to       <= 1'b0;
    end else begin
      st        <= nxt;
      data_mode <= nxt_dm;
      if (st == ST_START) begin
        sh_force    <= force_code;
        sh_an_en    <= an_en;
        sh_fec_req  <= fec_req;
        partner_fec <= 1'b0;
      end else if (st == ST_AN_WAIT && an_done && !restart) begin
        partner_fec <= an_partner_fec;
      end
      if (an_start_evt)    an_to <= 1'b0;
      else if (an_tmo_evt) an_to <= 1'b1;
      if (st == ST_START)  lt_to <= 1'b0;
      else if (lt_tmo_evt) lt_to <= 1'b1;
    end
  end
endmodule

// File: rtl/bp_link_seq.sv
module bp_link_seq
  import bls_pkg::*;
#(
  parameter int AN_TMO = 1000,
  parameter int LT_TMO = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_restart,
  input  logic [3:0]        cfg_force,
  input  logic              cfg_an_en,
  input  logic              cfg_fec_req,
  input  logic              cfg_lt_fail_data,
  input  logic              cfg_err_ins,
  input  logic              an_done,
  input  logic              an_res_10g,
  input  logic              an_partner_fec,
  input  logic              lt_done,
  input  logic              lt_fail,
  input  logic              rcfg_done,
  output logic [MODE_W-1:0] rcfg_mode,
  output logic              link_ready,
  output logic              an_timeout,
  output logic              lt_timeout,
  output logic              fec_err_pulse
);
  localparam int NTMR = 2;
  localparam int TMO_LIM [NTMR] = '{AN_TMO, LT_TMO};

  seq_st_t           st;
  logic [MODE_W-1:0] data_mode;
  logic [NTMR-1:0]   tmr_run;
  logic [NTMR-1:0]   tmr_exp;
  logic              an_tmo_evt;
  logic              lt_tmo_evt;
  logic              an_start_evt;
  logic              req_hold;

  assign tmr_run[0] = (st == ST_AN_WAIT);
  assign tmr_run[1] = (st == ST_LT_WAIT);

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    bls_timer #(.LIMIT(TMO_LIM[g])) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run[g]),
      .expired (tmr_exp[g])
    );
  end

  bls_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .restart        (cfg_restart),
    .force_code     (cfg_force),
    .an_en          (cfg_an_en),
    .fec_req        (cfg_fec_req),
    .lt_fail_data   (cfg_lt_fail_data),
    .an_done        (an_done),
    .an_res_10g     (an_res_10g),
    .an_partner_fec (an_partner_fec),
    .lt_done        (lt_done),
    .lt_fail        (lt_fail),
    .rcfg_done      (rcfg_done),
    .an_expired     (tmr_exp[0]),
    .lt_expired     (tmr_exp[1]),
    .st             (st),
    .data_mode      (data_mode),
    .an_to          (an_timeout),
    .lt_to          (lt_timeout),
    .an_tmo_evt     (an_tmo_evt),
    .lt_tmo_evt     (lt_tmo_evt),
    .an_start_evt   (an_start_evt)
  );

  bls_err_pulse u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_err_ins),
    .pulse (fec_err_pulse)
  );

  assign rcfg_mode  = mode_of(st, data_mode);
  assign link_ready = (st == ST_DATA);
  assign req_hold   = (st == ST_AN_REQ) || (st == ST_LT_REQ) || (st == ST_DAT_REQ);
endmodule

// File: rtl/bls_checker.sv
module bls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_restart,
  input logic       cfg_err_ins,
  input logic       rcfg_done,
  input logic [5:0] rcfg_mode,
  input logic       link_ready,
  input logic       an_timeout,
  input logic       lt_timeout,
  input logic       fec_err_pulse,
  input logic       an_tmo_evt,
  input logic       lt_tmo_evt,
  input logic       an_start_evt,
  input logic       req_hold
);
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rcfg_mode)); // R3
  AST_NO_XAUI_BIT: assert property (@(posedge clk) disable iff (!rst_n) !rcfg_mode[4]); // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hold && !rcfg_done && !cfg_restart) |=> $stable(rcfg_mode)); // R4
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_restart |=> (rcfg_mode == 6'b0 && !link_ready)); // R13
  AST_READY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> (rcfg_mode[2] || rcfg_mode[3] || rcfg_mode[5])); // R11
  AST_AN_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    an_tmo_evt |=> an_timeout); // R8
  AST_AN_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (an_timeout && !an_start_evt) |=> an_timeout); // R8
  AST_AN_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    an_start_evt |=> !an_timeout); // R8
  AST_LT_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lt_tmo_evt |=> lt_timeout); // R9
  AST_ERR_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_ins |=> fec_err_pulse); // R12
  AST_ERR_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err_ins |=> !fec_err_pulse); // R12
endmodule

bind bp_link_seq bls_checker u_bls_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_restart   (cfg_restart),
  .cfg_err_ins   (cfg_err_ins),
  .rcfg_done     (rcfg_done),
  .rcfg_mode     (rcfg_mode),
  .link_ready    (link_ready),
  .an_timeout    (an_timeout),
  .lt_timeout    (lt_timeout),
  .fec_err_pulse (fec_err_pulse),
  .an_tmo_evt    (an_tmo_evt),
  .lt_tmo_evt    (lt_tmo_evt),
  .an_start_evt  (an_start_evt),
  .req_hold      (req_hold)
);

// File: tb/test_bp_link_seq.sv
module test_bp_link_seq;
  localparam int AN_T = 40;
  localparam int LT_T = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_restart = 1'b0;
  logic [3:0] cfg_force = 4'b0000;
  logic       cfg_an_en = 1'b1;
  logic       cfg_fec_req = 1'b1;
  logic       cfg_lt_fail_data = 1'b0;
  logic       cfg_err_ins = 1'b0;
  logic       an_done = 1'b0;
  logic       an_res_10g = 1'b0;
  logic       an_partner_fec = 1'b0;
  logic       lt_done = 1'b0;
  logic       lt_fail = 1'b0;
  logic       rcfg_done = 1'b0;
  logic [5:0] rcfg_mode;
  logic       link_ready;
  logic       an_timeout;
  logic       lt_timeout;
  logic       fec_err_pulse;

  int         vectors = 0;
  int         errs = 0;
  bit         done_flag = 1'b0;
  string      cur_req = "R1";
  logic [5:0] exp_q[$];
  logic [5:0] last_mode = 6'b0;
  logic [5:0] exp_item;

  always #5 clk = ~clk;

  bp_link_seq #(.AN_TMO(AN_T), .LT_TMO(LT_T)) i_bp_link_seq (
    .clk(clk), .rst_n(rst_n), .cfg_restart(cfg_restart), .cfg_force(cfg_force),
    .cfg_an_en(cfg_an_en), .cfg_fec_req(cfg_fec_req), .cfg_lt_fail_data(cfg_lt_fail_data),
    .cfg_err_ins(cfg_err_ins), .an_done(an_done), .an_res_10g(an_res_10g),
    .an_partner_fec(an_partner_fec), .lt_done(lt_done), .lt_fail(lt_fail),
    .rcfg_done(rcfg_done), .rcfg_mode(rcfg_mode), .link_ready(link_ready),
    .an_timeout(an_timeout), .lt_timeout(lt_timeout), .fec_err_pulse(fec_err_pulse)
  );

  // Monitor: every change of the mode request is matched against the queue.
  always @(negedge clk) begin
    if (rst_n && rcfg_mode !== last_mode) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL %s mode change act=%b exp=<none>", cur_req, rcfg_mode);
      end else begin
        exp_item = exp_q.pop_front();
        if (exp_item !== rcfg_mode) begin
          errs++;
          $display("FAIL %s mode sequence act=%b exp=%b", cur_req, rcfg_mode, exp_item);
        end
      end
      last_mode = rcfg_mode;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expect_mode(logic [5:0] m);
    exp_q.push_back(m);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart();
    @(negedge clk); cfg_restart = 1'b1;
    @(negedge clk); cfg_restart = 1'b0;
  endtask

  task automatic give_rcfg();
    @(negedge clk); rcfg_done = 1'b1;
    @(negedge clk); rcfg_done = 1'b0;
  endtask

  task automatic give_an(logic r10g, logic pfec);
    @(negedge clk); an_done = 1'b1; an_res_10g = r10g; an_partner_fec = pfec;
    @(negedge clk); an_done = 1'b0;
  endtask

  task automatic give_lt_done();
    @(negedge clk); lt_done = 1'b1;
    @(negedge clk); lt_done = 1'b0;
  endtask

  task automatic give_lt_fail();
    @(negedge clk); lt_fail = 1'b1;
    @(negedge clk); lt_fail = 1'b0;
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL %s watchdog act=running exp=finished", cur_req);
    summary();
  end

  initial begin
    // R1: reset state
    wait_cyc(4);
    chk("R1 mode in reset", 32'(rcfg_mode), 32'h0);
    chk("R1 ready in reset", 32'(link_ready), 32'h0);
    chk("R1 an flag in reset", 32'(an_timeout), 32'h0);
    chk("R12 no pulse in reset", 32'(fec_err_pulse), 32'h0);
    expect_mode(6'b000001);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 first request AN", 32'(rcfg_mode), 32'h01);

    // R4: outcome before acknowledge is ignored
    cur_req = "R4";
    wait_cyc(5);
    give_an(1'b1, 1'b1);
    wait_cyc(1);
    chk("R4 AN held without rcfg_done", 32'(rcfg_mode), 32'h01);

    // R10: FEC request dropped mid-run has no effect; R6 FEC chosen
    cur_req = "R10";
    cfg_fec_req = 1'b0;
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b1);
    give_rcfg();
    expect_mode(6'b100000);
    give_lt_done();
    chk("R11 not ready before ack", 32'(link_ready), 32'h0);
    give_rcfg();
    chk("R11 ready after ack", 32'(link_ready), 32'h1);
    chk("R10 FEC kept from restart sample", 32'(rcfg_mode), 32'h20);
    cfg_force = 4'b0001;
    wait_cyc(4);
    chk("R10 force change ignored", 32'(rcfg_mode), 32'h20);
    chk("R10 link kept", 32'(link_ready), 32'h1);

    // R2: forced GigE
    cur_req = "R2";
    expect_mode(6'b000000); expect_mode(6'b001000);
    do_restart();
    wait_cyc(1);
    chk("R3 GigE data encoding", 32'(rcfg_mode), 32'h08);
    give_rcfg();
    chk("R11 forced GigE ready", 32'(link_ready), 32'h1);

    // R6: plain 10G when FEC not requested
    cur_req = "R6";
    cfg_force = 4'b0000;
    expect_mode(6'b000000); expect_mode(6'b000001);
    do_restart();
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b1);
    give_rcfg();
    expect_mode(6'b000100);
    give_lt_done();
    chk("R6 plain 10G data", 32'(rcfg_mode), 32'h04);

    // R5: AN resolves GigE
    cur_req = "R5";
    expect_mode(6'b000000); expect_mode(6'b000001);
    do_restart();
    give_rcfg();
    expect_mode(6'b001000);
    give_an(1'b0, 1'b0);
    chk("R5 GigE after AN", 32'(rcfg_mode), 32'h08);

    // R7: failure responses
    cur_req = "R7";
    cfg_fec_req = 1'b1;
    expect_mode(6'b000000); expect_mode(6'b000001);
    do_restart();
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b1);
    give_rcfg();
    expect_mode(6'b000001);
    give_lt_fail();
    chk("R7 fail restarts AN", 32'(rcfg_mode), 32'h01);
    cfg_lt_fail_data = 1'b1;
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b1);
    give_rcfg();
    expect_mode(6'b100000);
    give_lt_fail();
    chk("R7 fail goes to data", 32'(rcfg_mode), 32'h20);
    give_rcfg();
    chk("R7 link after fail-to-data", 32'(link_ready), 32'h1);
    cfg_lt_fail_data = 1'b0;
    cfg_an_en = 1'b0;
    expect_mode(6'b000000); expect_mode(6'b000010);
    do_restart();
    give_rcfg();
    give_lt_fail();
    wait_cyc(2);
    chk("R7 fail retrains without AN", 32'(rcfg_mode), 32'h02);
    chk("R7 no link after retrain", 32'(link_ready), 32'h0);
    give_rcfg();
    expect_mode(6'b000100);
    give_lt_done();
    chk("R6 no AN gives plain 10G", 32'(rcfg_mode), 32'h04);

    // R8: AN timeout
    cur_req = "R8";
    cfg_an_en = 1'b1;
    expect_mode(6'b000000); expect_mode(6'b000001);
    do_restart();
    give_rcfg();
    wait_cyc(AN_T + 4);
    chk("R8 an flag set", 32'(an_timeout), 32'h1);
    chk("R8 AN re-requested", 32'(rcfg_mode), 32'h01);
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b0);
    chk("R8 an flag sticky", 32'(an_timeout), 32'h1);
    give_rcfg();
    expect_mode(6'b000001);
    give_lt_fail();
    chk("R8 an flag cleared by new attempt", 32'(an_timeout), 32'h0);

    // R9: LT timeout
    cur_req = "R9";
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b0);
    give_rcfg();
    chk("R9 lt flag clear before", 32'(lt_timeout), 32'h0);
    expect_mode(6'b000001);
    wait_cyc(LT_T + 4);
    chk("R9 lt flag set", 32'(lt_timeout), 32'h1);
    chk("R9 timeout restarts AN", 32'(rcfg_mode), 32'h01);
    cfg_lt_fail_data = 1'b1;
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b0);
    give_rcfg();
    expect_mode(6'b000100);
    wait_cyc(LT_T + 4);
    chk("R9 timeout goes to data", 32'(rcfg_mode), 32'h04);
    cfg_lt_fail_data = 1'b0;
    cur_req = "R1";
    expect_mode(6'b000000); expect_mode(6'b000001);
    do_restart();
    wait_cyc(1);
    chk("R1 lt flag cleared by restart", 32'(lt_timeout), 32'h0);

    // R2: remaining force codes
    cur_req = "R2";
    cfg_force = 4'b0100;
    expect_mode(6'b000000); expect_mode(6'b000100);
    do_restart();
    wait_cyc(1);
    chk("R2 forced 10G", 32'(rcfg_mode), 32'h04);
    cfg_force = 4'b0010;
    expect_mode(6'b000000);
    do_restart();
    wait_cyc(5);
    chk("R2 XAUI code parks", 32'(rcfg_mode), 32'h00);
    cfg_force = 4'b1100;
    cfg_fec_req = 1'b0;
    expect_mode(6'b000001);
    do_restart();
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b1, 1'b0);
    give_rcfg();
    expect_mode(6'b100000);
    give_lt_done();
    chk("R2 KR FEC force", 32'(rcfg_mode), 32'h20);
    cfg_force = 4'b0101;
    cfg_fec_req = 1'b1;
    expect_mode(6'b000000); expect_mode(6'b000001);
    do_restart();
    give_rcfg();
    expect_mode(6'b000010);
    give_an(1'b0, 1'b1);
    give_rcfg();
    expect_mode(6'b000100);
    give_lt_done();
    chk("R2 KR force no FEC", 32'(rcfg_mode), 32'h04);

    // R13 and R12: restart, ack and error insert in one cycle
    cur_req = "R13";
    cfg_force = 4'b0000;
    expect_mode(6'b000000); expect_mode(6'b000001);
    @(negedge clk);
    cfg_restart = 1'b1; rcfg_done = 1'b1; cfg_err_ins = 1'b1;
    @(negedge clk);
    cfg_restart = 1'b0; rcfg_done = 1'b0; cfg_err_ins = 1'b0;
    chk("R13 ack discarded by restart", 32'(link_ready), 32'h0);
    chk("R12 error pulse issued", 32'(fec_err_pulse), 32'h1);
    wait_cyc(1);
    chk("R12 error pulse single cycle", 32'(fec_err_pulse), 32'h0);
    chk("R13 new AN request", 32'(rcfg_mode), 32'h01);

    wait_cyc(3);
    cur_req = "R4";
    chk("R4 all expected modes seen", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule